// File: doc/BRIEF.md
# Atomic 16-bit Timer Register Access Bridge

This block sits between a byte-wide processor bus and the 16-bit registers of one timer: a free-running counter, two compare words and a capture word. Every 16-bit word is reached through two byte accesses. A single byte-wide holding latch, shared by all four words, stages the upper byte. Because of it, a word is always committed whole and always read as one coherent value, even while the counter keeps moving.

Software writes the upper byte first and then the lower byte. The lower-byte write moves the held upper byte and the new lower byte into the word on one clock edge. Software reads the lower byte first. That read returns the live lower byte and copies the live upper byte into the holding latch, and the upper-byte read that follows returns the latch. Compare words take no part in the read snapshot: both of their bytes come straight from storage. On the timer side the block takes a count enable and a capture strobe, and it presents all four words in parallel.

Top module: `tmr16_access_bridge`

## Requirements
- R1: The byte address `addr_i` has this layout: bit 0 selects the upper byte (1) or the lower byte (0), and bits 2:1 select the word (0 counter, 1 compare A, 2 compare B, 3 capture). After reset, all four words and the holding latch are zero.
- R2: A write to any upper-byte address loads `wdata_i` into the holding latch and leaves every word unchanged.
- R3: A write to a lower-byte address loads {holding latch, `wdata_i`} into the selected word at that clock edge. The holding latch keeps its value.
- R4: A read of the counter or capture lower byte returns that word's live lower byte in the same cycle. At that edge it copies the word's upper byte into the holding latch. When `wr_i` and `rd_i` are both high, only the write acts.
- R5: A read of the counter or capture upper byte returns the holding latch, not the live upper byte.
- R6: Reads of either compare word return both bytes straight from the stored value and leave the holding latch unchanged.
- R7: One holding latch serves all words. An upper byte written at one word's address is used by a later lower-byte write to any other word.
- R8: While `count_en_i` is high, the counter steps by one per clock and wraps from 0xFFFF to 0x0000.
- R9: A lower-byte write to the counter in a cycle where `count_en_i` is high loads the written value, and no increment is applied in that cycle.
- R10: `capture_i` copies the current counter value into the capture word. A lower-byte write to the capture word in the same cycle takes priority.
- R11: A capture event that occurs between the lower-byte and upper-byte reads of the capture word does not change the upper byte returned.
- R12: A lower-then-upper read of the running counter returns a value the counter actually held, including when the lower byte rolls from 0xFF to 0x00 between the two reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 3 | Byte address: bits 2:1 select the word, bit 0 selects the upper byte |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | BYTE_W | Write data byte |
| rdata_o | output | BYTE_W | Read data byte, combinational from the address |
| count_en_i | input | 1 | Counter increment enable |
| capture_i | input | 1 | Capture strobe: copies the counter into the capture word |
| cnt_o | output | 2*BYTE_W | Counter value |
| cmp_a_o | output | 2*BYTE_W | Compare A value |
| cmp_b_o | output | 2*BYTE_W | Compare B value |
| cap_o | output | 2*BYTE_W | Capture value |

## Verification
The assertions check several behaviours on every clock edge:
- upper-byte writes leave the compare words unchanged;
- lower-byte writes commit the latch together with the data byte;
- lower-byte reads snapshot the upper byte, and upper-byte reads return the latch;
- compare reads leave the latch untouched;
- the counter increments and the capture load occur when no commit competes with them.

Other behaviours need a sequence of operations, and only the bench's scenarios can show them:
- the latch is shared across different words;
- the snapshot is unaffected by a capture that arrives between the two reads;
- read pairs taken from a running counter are coherent across a lower-byte rollover;
- the counter wraps at 0xFFFF.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int NUM_REGS = 4;

  typedef enum logic [1:0] {
    SEL_CNT  = 2'd0,
    SEL_CMPA = 2'd1,
    SEL_CMPB = 2'd2,
    SEL_CAP  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tmr16_addr_dec.sv
module tmr16_addr_dec
  import tmr16_pkg::*;
(
  input  logic [2:0]          addr_i,
  input  logic                wr_i,
  input  logic                rd_i,
  output logic [NUM_REGS-1:0] commit_o,
  output logic                tmp_wr_o,
  output logic                snap_cnt_o,
  output logic                snap_cap_o
);
  reg_sel_e sel;
  logic     hi;

  assign sel = reg_sel_e'(addr_i[2:1]);
  assign hi  = addr_i[0];

  always_comb begin
    commit_o = '0;
    if (wr_i && !hi) commit_o[sel] = 1'b1;
  end

  assign tmp_wr_o = wr_i && hi;
  // write wins over a simultaneous read: no snapshot
  assign snap_cnt_o = rd_i && !wr_i && !hi && (sel == SEL_CNT);
  assign snap_cap_o = rd_i && !wr_i && !hi && (sel == SEL_CAP);
endmodule

// File: rtl/tmr16_tmp_latch.sv
module tmr16_tmp_latch #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] load_byte_i,
  input  logic              snap_i,
  input  logic [BYTE_W-1:0] snap_byte_i,
  output logic [BYTE_W-1:0] tmp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tmp_o <= '0;
    else if (load_i) tmp_o <= load_byte_i;
    else if (snap_i) tmp_o <= snap_byte_i;
  end
endmodule

// File: rtl/tmr16_word_reg.sv
module tmr16_word_reg #(
  parameter int BYTE_W   = 8,
  parameter bit COUNTS   = 1'b0,
  parameter bit CAPTURES = 1'b0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                commit_i,
  input  logic [2*BYTE_W-1:0] commit_word_i,
  input  logic                event_i,
  input  logic [2*BYTE_W-1:0] cap_word_i,
  output logic [2*BYTE_W-1:0] q_o
);
  localparam int WORD_W = 2 * BYTE_W;

  logic [WORD_W-1:0] q_d;

  generate
    if (COUNTS) begin : g_counter
      logic unused_cap;
      assign unused_cap = ^cap_word_i;
      // CPU commit beats increment
      always_comb begin
        q_d = q_o;
        if (commit_i)     q_d = commit_word_i;
        else if (event_i) q_d = q_o + 1'b1;
      end

      // R8
      inc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        event_i && !commit_i |=> q_o == $past(q_o) + 1'b1);
    end else if (CAPTURES) begin : g_capture
      always_comb begin
        q_d = q_o;
        if (commit_i)     q_d = commit_word_i;
        else if (event_i) q_d = cap_word_i;
      end

      // R10
      cap_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        event_i && !commit_i |=> q_o == $past(cap_word_i));
    end else begin : g_plain
      logic unused_evt;
      assign unused_evt = ^{event_i, cap_word_i};
      always_comb begin
        q_d = q_o;
        if (commit_i) q_d = commit_word_i;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= q_d;
  end
endmodule

// File: rtl/tmr16_access_bridge.sv
module tmr16_access_bridge
  import tmr16_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [2:0]          addr_i,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [BYTE_W-1:0]   wdata_i,
  output logic [BYTE_W-1:0]   rdata_o,
  input  logic                count_en_i,
  input  logic                capture_i,
  output logic [2*BYTE_W-1:0] cnt_o,
  output logic [2*BYTE_W-1:0] cmp_a_o,
  output logic [2*BYTE_W-1:0] cmp_b_o,
  output logic [2*BYTE_W-1:0] cap_o
);
  localparam int WORD_W = 2 * BYTE_W;

  logic [NUM_REGS-1:0] commit;
  logic                tmp_wr, snap_cnt, snap_cap;
  logic [BYTE_W-1:0]   tmp_q, snap_byte;
  logic [WORD_W-1:0]   word_q [NUM_REGS];
  logic [WORD_W-1:0]   commit_word;
  reg_sel_e            sel;
  logic                hi;

  assign sel = reg_sel_e'(addr_i[2:1]);
  assign hi  = addr_i[0];

  tmr16_addr_dec u_dec (
    .addr_i     (addr_i),
    .wr_i       (wr_i),
    .rd_i       (rd_i),
    .commit_o   (commit),
    .tmp_wr_o   (tmp_wr),
    .snap_cnt_o (snap_cnt),
    .snap_cap_o (snap_cap)
  );

  assign snap_byte = snap_cap ? word_q[SEL_CAP][WORD_W-1:BYTE_W]
                              : word_q[SEL_CNT][WORD_W-1:BYTE_W];

  tmr16_tmp_latch #(.BYTE_W(BYTE_W)) u_tmp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (tmp_wr),
    .load_byte_i (wdata_i),
    .snap_i      (snap_cnt | snap_cap),
    .snap_byte_i (snap_byte),
    .tmp_o       (tmp_q)
  );

  assign commit_word = {tmp_q, wdata_i};

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
      tmr16_word_reg #(
        .BYTE_W   (BYTE_W),
        .COUNTS   (i == int'(SEL_CNT)),
        .CAPTURES (i == int'(SEL_CAP))
      ) u_word (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .commit_i      (commit[i]),
        .commit_word_i (commit_word),
        .event_i       ((i == int'(SEL_CNT)) ? count_en_i : capture_i),
        .cap_word_i    (word_q[SEL_CNT]),
        .q_o           (word_q[i])
      );
    end
  endgenerate

  always_comb begin
    if (!hi)                                  rdata_o = word_q[sel][BYTE_W-1:0];
    else if (sel == SEL_CMPA || sel == SEL_CMPB) rdata_o = word_q[sel][WORD_W-1:BYTE_W];
    else                                      rdata_o = tmp_q;
  end

  assign cnt_o   = word_q[SEL_CNT];
  assign cmp_a_o = word_q[SEL_CMPA];
  assign cmp_b_o = word_q[SEL_CMPB];
  assign cap_o   = word_q[SEL_CAP];

  // R2
  hi_wr_no_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && hi |=> $stable(cmp_a_o) && $stable(cmp_b_o));

  // R3
  lo_wr_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !hi && sel == SEL_CMPA |=> cmp_a_o == {$past(tmp_q), $past(wdata_i)});

  // R9
  cnt_wr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !hi && sel == SEL_CNT |=> cnt_o == {$past(tmp_q), $past(wdata_i)});

  // R4
  lo_rd_snap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !wr_i && !hi && sel == SEL_CNT |=> tmp_q == $past(cnt_o[WORD_W-1:BYTE_W]));

  // R4
  lo_rd_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !hi && sel == SEL_CAP |-> rdata_o == cap_o[BYTE_W-1:0]);

  // R5
  hi_rd_tmp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && hi && (sel == SEL_CNT || sel == SEL_CAP) |-> rdata_o == tmp_q);

  // R6
  cmp_rd_bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !wr_i && (sel == SEL_CMPA || sel == SEL_CMPB) |=> $stable(tmp_q));
endmodule

// File: tb/test_tmr16_access_bridge.sv
`timescale 1ns/1ps
module test_tmr16_access_bridge;
  localparam logic [2:0] A_CNT_L = 3'd0, A_CNT_H = 3'd1, A_CA_L = 3'd2, A_CA_H = 3'd3,
                         A_CB_L  = 3'd4, A_CB_H  = 3'd5, A_CP_L = 3'd6, A_CP_H = 3'd7;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0, count_en = 1'b0, capture = 1'b0;
  logic [7:0]  wdata = '0, rdata;
  logic [15:0] cnt, cmp_a, cmp_b, cap;
  int          n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  tmr16_access_bridge i_tmr16_access_bridge (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .count_en_i(count_en), .capture_i(capture),
    .cnt_o(cnt), .cmp_a_o(cmp_a), .cmp_b_o(cmp_b), .cap_o(cap));

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cpu_wr(logic [2:0] a, logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    step();
    wr = 1'b0;
  endtask

  task automatic cpu_rd(logic [2:0] a, output logic [7:0] d);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    step();
    rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] b;
    chk("R1 cnt", cnt, 16'h0); chk("R1 cmp_a", cmp_a, 16'h0);
    chk("R1 cmp_b", cmp_b, 16'h0); chk("R1 cap", cap, 16'h0);
    rst_n = 1'b1;
    step();
    cpu_rd(A_CNT_H, b);
    chk("R1 latch", {8'h0, b}, 16'h0);
  endtask

  task automatic t_write_order();
    logic [7:0] b;
    cpu_wr(A_CA_H, 8'hAB);
    chk("R2 target unchanged", cmp_a, 16'h0000);
    cpu_wr(A_CA_L, 8'hCD);
    chk("R3 commit", cmp_a, 16'hABCD);
    cpu_wr(A_CA_L, 8'h11);
    chk("R3 latch kept", cmp_a, 16'hAB11);
    cpu_rd(A_CA_L, b); chk("R6 cmp lo", {8'h0, b}, 16'h0011);
    cpu_rd(A_CA_H, b); chk("R6 cmp hi", {8'h0, b}, 16'h00AB);
  endtask

  task automatic t_shared();
    cpu_wr(A_CB_H, 8'h5A);
    cpu_wr(A_CP_L, 8'h3C);
    chk("R7 cap via shared latch", cap, 16'h5A3C);
    chk("R7 cmp_b untouched", cmp_b, 16'h0000);
  endtask

  task automatic t_bypass();
    logic [7:0] b;
    cpu_wr(A_CNT_H, 8'h77);
    chk("R2 cnt unchanged", cnt, 16'h0000);
    cpu_rd(A_CA_H, b); chk("R6 cmp hi ignores latch", {8'h0, b}, 16'h00AB);
    cpu_rd(A_CB_L, b); chk("R6 cmp_b lo", {8'h0, b}, 16'h0000);
    cpu_rd(A_CNT_H, b); chk("R6 latch untouched", {8'h0, b}, 16'h0077);
  endtask

  task automatic t_snapshot();
    logic [7:0] b;
    cpu_wr(A_CNT_H, 8'h12); cpu_wr(A_CNT_L, 8'hFF);
    cpu_rd(A_CNT_L, b); chk("R4 live lo", {8'h0, b}, 16'h00FF);
    count_en = 1'b1; step(); count_en = 1'b0;
    chk("R8 cnt moved", cnt, 16'h1300);
    cpu_rd(A_CNT_H, b); chk("R5 hi from latch", {8'h0, b}, 16'h0012);
    // simultaneous rd+wr at counter low: write only, no snapshot
    cpu_wr(A_CB_H, 8'h44);
    addr = A_CNT_L; wdata = 8'h01; wr = 1'b1; rd = 1'b1;
    step(); wr = 1'b0; rd = 1'b0;
    chk("R4 wr beats rd", cnt, 16'h4401);
    cpu_rd(A_CNT_H, b); chk("R4 no snapshot on wr", {8'h0, b}, 16'h0044);
  endtask

  task automatic t_wrap();
    cpu_wr(A_CNT_H, 8'hFF); cpu_wr(A_CNT_L, 8'hFE);
    count_en = 1'b1;
    step(); chk("R8 step", cnt, 16'hFFFF);
    step(); chk("R8 wrap", cnt, 16'h0000);
    step(); chk("R8 after wrap", cnt, 16'h0001);
    count_en = 1'b0;
  endtask

  task automatic t_wr_wins();
    count_en = 1'b1;
    cpu_wr(A_CNT_H, 8'h40);
    cpu_wr(A_CNT_L, 8'h00);
    chk("R9 write wins", cnt, 16'h4000);
    step(); chk("R9 counts after", cnt, 16'h4001);
    count_en = 1'b0;
  endtask

  task automatic t_capture();
    cpu_wr(A_CNT_H, 8'h0A); cpu_wr(A_CNT_L, 8'h0B);
    capture = 1'b1; step(); capture = 1'b0;
    chk("R10 capture", cap, 16'h0A0B);
    cpu_wr(A_CP_H, 8'h99);
    capture = 1'b1; cpu_wr(A_CP_L, 8'h88); capture = 1'b0;
    chk("R10 write beats capture", cap, 16'h9988);
  endtask

  task automatic t_cap_snapshot();
    logic [7:0] b;
    cpu_wr(A_CNT_H, 8'h55); cpu_wr(A_CNT_L, 8'h66);
    cpu_wr(A_CP_H, 8'h99); cpu_wr(A_CP_L, 8'h88);
    cpu_rd(A_CP_L, b); chk("R4 cap lo", {8'h0, b}, 16'h0088);
    capture = 1'b1; step(); capture = 1'b0;
    chk("R11 capture landed", cap, 16'h5566);
    cpu_rd(A_CP_H, b); chk("R11 snapshot held", {8'h0, b}, 16'h0099);
    cpu_rd(A_CP_L, b); chk("R11 new lo", {8'h0, b}, 16'h0066);
  endtask

  task automatic t_running();
    logic [7:0]  lo, hi;
    logic [15:0] live, at_lo;
    bit          saw_roll = 1'b0;
    cpu_wr(A_CNT_H, 8'h12); cpu_wr(A_CNT_L, 8'hF1);
    live = 16'h12F1;
    count_en = 1'b1;
    for (int k = 0; k < 20; k++) begin
      at_lo = live;
      cpu_rd(A_CNT_L, lo); live++;
      cpu_rd(A_CNT_H, hi);
      if (hi != live[15:8]) saw_roll = 1'b1;
      live++;
      chk("R12 coherent pair", {hi, lo}, at_lo);
    end
    count_en = 1'b0;
    chk("R12 rollover covered", {15'h0, saw_roll}, 16'h0001);
    chk("R12 counter tracked", cnt, live);
  endtask

  initial begin
    fork
      begin
        step(); step();
        t_reset();
        t_write_order();
        t_shared();
        t_bypass();
        t_snapshot();
        t_wrap();
        t_wr_wins();
        t_capture();
        t_cap_snapshot();
        t_running();
      end
      begin
        #1_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule